// File: doc/BRIEF.md
# Multi-Mode TDM Synchronous Serial Port

This block is a full-duplex synchronous serial port for attaching codecs and neighbouring processors. The transmit section loads parallel words into a one-word holding register and shifts them out most significant bit first. It produces its own bit clock, divided down from the system clock, and a frame-sync pulse. The receive section turns the serial stream back into parallel words. It can follow the transmitter's own clock and framing, or an external bit clock and frame sync that are brought into the system clock domain.

Three framing modes are available. Periodic mode sends one word in every frame and never pauses. On-demand mode starts a word only when the holding register has one. Network mode divides every frame into 2 to 32 time slots, and a per-slot mask selects the slots the transmitter drives. A gated option stops the serial clock outside word transfers. In that case no frame sync is sent, and the receiver takes word boundaries from the clock bursts. When a periodic slot finds the holding register empty, the previous word is sent again and an underrun pulse is raised.

Top module: `ssp_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `sck_o`, `fs_o`, `sd_oe`, `rx_valid` and `tx_underrun` are low and `tx_empty` is high.
- R2: With a continuous clock, one bit lasts 2*(`cfg_div`+1) system clocks, and `sck_o` is low for the first half and high for the second. The transmitter changes `sd_o` as the low half begins, and the internal receiver samples `sd_i` as `sck_o` rises.
- R3: `cfg_wlen` selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 24. Words are right-justified in `tx_word`/`rx_word` and sent most significant bit first.
- R4: `fs_o` is high for exactly the bit period of the first bit of a word in periodic and on-demand modes. In network mode it is high only for the first bit of slot 0.
- R5: Periodic mode (`cfg_mode`=0) sends words back to back, one per frame, with a frame sync on each.
- R6: On-demand mode (`cfg_mode`=1) starts a word only when the holding register is full. While it is empty, `fs_o` and `sd_oe` stay low.
- R7: Network mode (`cfg_mode`=2) has `cfg_last_slot`+1 slots per frame. In slot n the transmitter drives only when bit n of `cfg_slot_en` is 1. In a disabled slot `sd_oe` is low and the holding register is left untouched.
- R8: A driven periodic or network slot that finds the holding register empty resends the last word sent (zero after reset) and pulses `tx_underrun` for one cycle.
- R9: `tx_wr` loads `tx_word` only when `tx_empty` is high. A write while the register is full is ignored. `tx_empty` rises when a word moves into the shifter.
- R10: When `cfg_gated` is 1, transfers run on demand, `fs_o` stays low, and `sck_o` pulses only during word bits. At least one idle bit period follows every word.
- R11: With `cfg_rx_ext`=0, the receiver samples every word period of the transmitter, including disabled slots. It pulses `rx_valid` for one cycle with `rx_word` and the slot number in `rx_slot`.
- R12: With `cfg_rx_ext`=1, the receiver uses `sck_i`, `fs_i` and `sd_i` after two synchronising flops. A word begins at a rising `sck_i` edge where `fs_i` is high. Bits received before any frame sync are ignored. A following word without a sync continues in the next slot, wrapping after `cfg_last_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 periodic, 1 on-demand, 2 network (3 treated as on-demand) |
| cfg_wlen | input | 2 | Word length code |
| cfg_div | input | DIV_W | Half-bit length minus one, in system clocks |
| cfg_gated | input | 1 | Gated serial clock, no frame sync |
| cfg_rx_ext | input | 1 | Receiver follows the external clock and sync |
| cfg_last_slot | input | SLOT_W | Slots per network frame minus one |
| cfg_slot_en | input | SLOTS | Per-slot transmit enable |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_word | input | WORD_W | Word to send, right-justified |
| tx_empty | output | 1 | Holding register can take a word |
| tx_underrun | output | 1 | One-cycle pulse on a repeated word |
| rx_word | output | WORD_W | Received word, right-justified |
| rx_valid | output | 1 | One-cycle pulse with a new word |
| rx_slot | output | SLOT_W | Slot of the received word |
| sck_o | output | 1 | Serial bit clock out |
| fs_o | output | 1 | Frame sync out |
| sd_o | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for sd_o |
| sd_i | input | 1 | Serial data in |
| sck_i | input | 1 | External receive bit clock |
| fs_i | input | 1 | External receive frame sync |

## Verification
On-demand transfers loop the output back to the input and sweep all four word lengths and several divider settings. The data patterns have the top and bottom bits set, which exposes a wrong bit order or a truncated length. The bit sampled during the frame-sync period separates the most significant bit from its neighbours. Periodic mode with one written word tells repetition after underrun apart from fresh loading. Network frames with a sparse slot mask read a pulled-up line in the masked slots, which shows that the output is released there. A gated burst pair is checked by counting clock edges and measuring the widest gap between them. External-clock streams with leading junk bits and an unsynced second word check alignment to the frame sync and the slot advance.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam logic [1:0] MODE_PERIODIC = 2'd0;
    localparam logic [1:0] MODE_DEMAND   = 2'd1;
    localparam logic [1:0] MODE_NETWORK  = 2'd2;

    // word length code to number of bits
    function automatic logic [4:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd8;
            2'd1:    return 5'd12;
            2'd2:    return 5'd16;
            default: return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/ssp_bitclk.sv
module ssp_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             bit_stb,
    output logic             mid_stb,
    output logic             phase_hi
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             half;
    } bclk_t;

    bclk_t st_q, st_d;
    logic  term;

    always_comb begin
        st_d = st_q;
        term = (st_q.cnt == div);
        if (term) begin
            st_d.cnt  = '0;
            st_d.half = ~st_q.half;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign bit_stb  = term && st_q.half;
    assign mid_stb  = term && !st_q.half;
    assign phase_hi = st_q.half;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the clock level only changes after a terminal count
    a_r2_half_on_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.half != $past(st_q.half)) |-> $past(term));

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOTS  = 32,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BW     = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic [1:0]        mode,
    input  logic              gated,
    input  logic [BW-1:0]     wl,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic [SLOTS-1:0]  slot_en,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic              empty,
    output logic              underrun,
    output logic              sd,
    output logic              oe,
    output logic              fs,
    output logic              run,
    output logic [BW-1:0]     bit_idx,
    output logic [SLOT_W-1:0] slot
);
    typedef struct packed {
        logic              run;
        logic              drive;
        logic              fs;
        logic              full;
        logic              und;
        logic [BW-1:0]     bitn;
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] last;
    } tx_t;

    tx_t tq, td;
    logic load, eow, periodic, net;
    logic [SLOT_W-1:0] stop_slot, nslot;

    function automatic logic [WORD_W-1:0] align(input logic [WORD_W-1:0] w,
                                                input logic [BW-1:0] n);
        return w << (WORD_W - int'(n));
    endfunction

    always_comb begin
        td        = tq;
        td.und    = 1'b0;
        load      = 1'b0;
        net       = (mode == MODE_NETWORK);
        periodic  = !gated && (mode == MODE_PERIODIC || net);
        stop_slot = net ? last_slot : '0;
        eow       = tq.run && (tq.bitn == wl - 1'b1);
        nslot     = (tq.run && tq.slot != stop_slot) ? tq.slot + 1'b1 : '0;
        if (bit_stb) begin
            if (tq.run && !eow) begin
                td.bitn = tq.bitn + 1'b1;
                td.sh   = tq.sh << 1;
                td.fs   = 1'b0;
            end else if (periodic) begin
                td.run   = 1'b1;
                td.bitn  = '0;
                td.slot  = nslot;
                td.fs    = (nslot == '0);
                td.drive = net ? slot_en[nslot] : 1'b1;
                td.sh    = '0;
                if (td.drive) begin
                    if (tq.full) begin
                        load    = 1'b1;
                        td.sh   = align(tq.hold, wl);
                        td.last = tq.hold;
                    end else begin
                        td.sh  = align(tq.last, wl);
                        td.und = 1'b1;
                    end
                end
            end else begin
                td.fs   = 1'b0;
                td.bitn = '0;
                td.slot = '0;
                if (gated && eow) begin
                    td.run   = 1'b0;
                    td.drive = 1'b0;
                end else if (tq.full) begin
                    load     = 1'b1;
                    td.run   = 1'b1;
                    td.drive = 1'b1;
                    td.fs    = !gated;
                    td.sh    = align(tq.hold, wl);
                    td.last  = tq.hold;
                end else begin
                    td.run   = 1'b0;
                    td.drive = 1'b0;
                end
            end
        end
        if (load) td.full = 1'b0;
        if (wr && !tq.full) begin
            td.hold = wdata;
            td.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tq <= '0;
        else        tq <= td;
    end

    assign empty    = !tq.full;
    assign underrun = tq.und;
    assign oe       = tq.run && tq.drive;
    assign sd       = oe ? tq.sh[WORD_W-1] : 1'b0;
    assign fs       = tq.fs;
    assign run      = tq.run;
    assign bit_idx  = tq.bitn;
    assign slot     = tq.slot;

    // R8: an underrun is flagged once per word
    a_r8_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
        tq.und |=> !tq.und);
    // R9: a write into a full holding register leaves it unchanged
    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tq.full && wr && !load) |=> $stable(tq.hold));
    // R4: frame sync starts together with the first bit of a word
    a_r4_fs_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tq.fs) |-> (tq.run && tq.bitn == '0));
    // R7: the line is driven only in enabled slots
    a_r7_masked_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && net && !gated && $stable(slot_en)) |-> slot_en[tq.slot]);
    // R3: bit index stays within the word length
    a_r3_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tq.run && $stable(wl)) |-> (tq.bitn < wl));

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
    parameter int WORD_W = 24,
    parameter int SLOTS  = 32,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BW     = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic [BW-1:0]     wl,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic              mid_stb,
    input  logic              tx_run,
    input  logic [BW-1:0]     tx_bit,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic              sd_i,
    input  logic              sck_i,
    input  logic              fs_i,
    output logic [WORD_W-1:0] data,
    output logic              valid,
    output logic [SLOT_W-1:0] oslot
);
    typedef struct packed {
        logic [2:0]        s1;
        logic [2:0]        s2;
        logic              sck_prev;
        logic              on;
        logic [BW-1:0]     cnt;
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] data;
        logic              valid;
        logic [SLOT_W-1:0] oslot;
    } rx_t;

    rx_t rq, rd;
    logic ev, first, sbit;

    always_comb begin
        rd          = rq;
        rd.valid    = 1'b0;
        rd.s1       = {sck_i, fs_i, sd_i};
        rd.s2       = rq.s1;
        rd.sck_prev = rq.s2[2];
        if (ext_en) begin
            ev    = rq.s2[2] && !rq.sck_prev;
            first = rq.s2[1];
            sbit  = rq.s2[0];
        end else begin
            ev    = mid_stb && tx_run;
            first = (tx_bit == '0);
            sbit  = sd_i;
        end
        if (ev) begin
            if (first || (rq.on && rq.cnt == '0)) begin
                rd.sh  = {{(WORD_W-1){1'b0}}, sbit};
                rd.cnt = 1;
                rd.on  = 1'b1;
                if (first) rd.slot = ext_en ? '0 : tx_slot;
            end else if (rq.on) begin
                rd.sh  = {rq.sh[WORD_W-2:0], sbit};
                rd.cnt = rq.cnt + 1'b1;
            end
            if (rd.on && rd.cnt == wl) begin
                rd.valid = 1'b1;
                rd.data  = rd.sh;
                rd.oslot = rd.slot;
                rd.cnt   = '0;
                rd.slot  = (rd.slot == last_slot) ? '0 : rd.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rq <= '0;
        else        rq <= rd;
    end

    assign data  = rq.data;
    assign valid = rq.valid;
    assign oslot = rq.oslot;

    // R11: a received word is announced for exactly one cycle
    a_r11_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rq.valid |=> !rq.valid);

endmodule

// File: rtl/ssp_top.sv
module ssp_top
    import ssp_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOTS  = 32,
    parameter int DIV_W  = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BW     = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_wlen,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_gated,
    input  logic              cfg_rx_ext,
    input  logic [SLOT_W-1:0] cfg_last_slot,
    input  logic [SLOTS-1:0]  cfg_slot_en,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_empty,
    output logic              tx_underrun,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              sck_o,
    output logic              fs_o,
    output logic              sd_o,
    output logic              sd_oe,
    input  logic              sd_i,
    input  logic              sck_i,
    input  logic              fs_i
);
    logic              bit_stb, mid_stb, phase_hi;
    logic              tx_run;
    logic [BW-1:0]     tx_bit, wl;
    logic [SLOT_W-1:0] tx_slot, rx_last;

    assign wl      = BW'(wlen_bits(cfg_wlen));
    assign rx_last = (cfg_mode == MODE_NETWORK) ? cfg_last_slot : '0;

    ssp_bitclk #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .div(cfg_div),
        .bit_stb(bit_stb), .mid_stb(mid_stb), .phase_hi(phase_hi)
    );

    ssp_tx #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .mode(cfg_mode),
        .gated(cfg_gated), .wl(wl), .last_slot(cfg_last_slot),
        .slot_en(cfg_slot_en), .wr(tx_wr), .wdata(tx_word),
        .empty(tx_empty), .underrun(tx_underrun), .sd(sd_o), .oe(sd_oe),
        .fs(fs_o), .run(tx_run), .bit_idx(tx_bit), .slot(tx_slot)
    );

    ssp_rx #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_rx (
        .clk(clk), .rst_n(rst_n), .ext_en(cfg_rx_ext), .wl(wl),
        .last_slot(rx_last), .mid_stb(mid_stb), .tx_run(tx_run),
        .tx_bit(tx_bit), .tx_slot(tx_slot), .sd_i(sd_i), .sck_i(sck_i),
        .fs_i(fs_i), .data(rx_word), .valid(rx_valid), .oslot(rx_slot)
    );

    assign sck_o = phase_hi && (!cfg_gated || tx_run);

endmodule

// File: tb/sim_ssp_top.sv
module sim_ssp_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n;
    logic [1:0]  cfg_mode, cfg_wlen;
    logic [7:0]  cfg_div;
    logic        cfg_gated, cfg_rx_ext;
    logic [4:0]  cfg_last_slot;
    logic [31:0] cfg_slot_en;
    logic        tx_wr;
    logic [23:0] tx_word;
    logic        tx_empty, tx_underrun, rx_valid;
    logic [23:0] rx_word;
    logic [4:0]  rx_slot;
    logic        sck_o, fs_o, sd_o, sd_oe;
    logic        ext_mode, ext_sd, ext_fs, ext_sck;
    logic        sd_in;

    assign sd_in = ext_mode ? ext_sd : (sd_oe ? sd_o : 1'b1);

    ssp_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
        .cfg_div(cfg_div), .cfg_gated(cfg_gated), .cfg_rx_ext(cfg_rx_ext),
        .cfg_last_slot(cfg_last_slot), .cfg_slot_en(cfg_slot_en),
        .tx_wr(tx_wr), .tx_word(tx_word), .tx_empty(tx_empty),
        .tx_underrun(tx_underrun), .rx_word(rx_word), .rx_valid(rx_valid),
        .rx_slot(rx_slot), .sck_o(sck_o), .fs_o(fs_o), .sd_o(sd_o),
        .sd_oe(sd_oe), .sd_i(sd_in), .sck_i(ext_sck), .fs_i(ext_fs)
    );

    typedef struct packed {
        logic [1:0]  wl;
        logic [7:0]  div;
        logic [23:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'd1, 24'h0000A5},
        '{2'd1, 8'd1, 24'h0009C3},
        '{2'd2, 8'd2, 24'h008001},
        '{2'd3, 8'd1, 24'hF0F00F},
        '{2'd3, 8'd3, 24'h800001},
        '{2'd0, 8'd0, 24'h000081}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // port monitor
    logic        mon_clr;
    logic        prev_sck;
    int          cyc, rises, fs_n, und_n, oe_n, rx_n, last_rise, per, maxp;
    bit          have_rise;
    logic        fs_bit;
    logic [23:0] rx_log [8];
    logic [4:0]  slot_log [8];

    always @(negedge clk) begin
        if (mon_clr) begin
            cyc = 0; rises = 0; fs_n = 0; und_n = 0; oe_n = 0; rx_n = 0;
            last_rise = 0; per = 0; maxp = 0; have_rise = 0; fs_bit = 1'b0;
            prev_sck = sck_o;
        end else begin
            cyc++;
            if (sck_o && !prev_sck) begin
                rises++;
                if (have_rise) begin
                    per = cyc - last_rise;
                    if (per > maxp) maxp = per;
                end
                have_rise = 1;
                last_rise = cyc;
                if (fs_o) begin
                    fs_n++;
                    fs_bit = sd_o;
                end
            end
            prev_sck = sck_o;
            if (rx_valid) begin
                if (rx_n < 8) begin
                    rx_log[rx_n]   = rx_word;
                    slot_log[rx_n] = rx_slot;
                end
                rx_n++;
            end
            if (tx_underrun) und_n++;
            if (sd_oe) oe_n++;
        end
    end

    function automatic int wbits(input logic [1:0] c);
        case (c)
            2'd0: return 8;
            2'd1: return 12;
            2'd2: return 16;
            default: return 24;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode, input logic [1:0] wl,
                            input logic [7:0] dv, input logic g, input logic ext,
                            input logic [4:0] last, input logic [31:0] en);
        tick();
        rst_n = 1'b0; mon_clr = 1'b1;
        cfg_mode = mode; cfg_wlen = wl; cfg_div = dv; cfg_gated = g;
        cfg_rx_ext = ext; cfg_last_slot = last; cfg_slot_en = en;
        tx_wr = 1'b0; tx_word = '0;
        ext_mode = ext; ext_sd = 1'b0; ext_fs = 1'b0; ext_sck = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1; mon_clr = 1'b0;
    endtask

    task automatic wr_raw(input logic [23:0] w);
        tick();
        tx_wr = 1'b1; tx_word = w;
        tick();
        tx_wr = 1'b0;
    endtask

    task automatic push(input logic [23:0] w);
        int t = 0;
        while (!tx_empty && t < 5000) begin tick(); t++; end
        wr_raw(w);
    endtask

    task automatic wait_rx(input int n);
        int t = 0;
        while (rx_n < n && t < 5000) begin tick(); t++; end
    endtask

    task automatic ext_bit(input logic f, input logic b);
        tick();
        ext_sd = b; ext_fs = f; ext_sck = 1'b0;
        repeat (3) tick();
        ext_sck = 1'b1;
        repeat (3) tick();
    endtask

    task automatic ext_word(input bit with_fs, input logic [11:0] w);
        for (int i = 11; i >= 0; i--) ext_bit(with_fs && i == 11, w[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mon_clr = 1'b1;
        cfg_mode = 2'd1; cfg_wlen = 2'd0; cfg_div = 8'd1; cfg_gated = 1'b0;
        cfg_rx_ext = 1'b0; cfg_last_slot = '0; cfg_slot_en = '0;
        tx_wr = 1'b0; tx_word = '0;
        ext_mode = 1'b0; ext_sd = 1'b0; ext_fs = 1'b0; ext_sck = 1'b0;

        // R1: reset state
        do_reset(2'd1, 2'd0, 8'd1, 1'b0, 1'b0, 5'd0, 32'h0);
        chk({sck_o, fs_o, sd_oe, rx_valid, tx_underrun, tx_empty} == 6'b000001,
            "R1 reset outputs",
            {26'd0, sck_o, fs_o, sd_oe, rx_valid, tx_underrun, tx_empty}, 32'h1);

        // R2 R3 R4 R11: on-demand loopback vectors
        foreach (VECS[i]) begin
            do_reset(2'd1, VECS[i].wl, VECS[i].div, 1'b0, 1'b0, 5'd0, 32'h0);
            push(VECS[i].data);
            wait_rx(1);
            chk(rx_n == 1 && rx_log[0] == VECS[i].data, "R3 R11 loopback word",
                {8'd0, rx_log[0]}, {8'd0, VECS[i].data});
            chk(fs_bit == VECS[i].data[wbits(VECS[i].wl)-1], "R4 msb in sync bit",
                {31'd0, fs_bit}, {31'd0, VECS[i].data[wbits(VECS[i].wl)-1]});
            chk(maxp == 2 * (int'(VECS[i].div) + 1), "R2 bit period",
                maxp, 2 * (int'(VECS[i].div) + 1));
            chk(fs_n == 1, "R4 R6 one sync per word", fs_n, 1);
            chk(slot_log[0] == 5'd0, "R11 slot zero", {27'd0, slot_log[0]}, 0);
        end

        // R6: on-demand with nothing written stays silent
        do_reset(2'd1, 2'd0, 8'd1, 1'b0, 1'b0, 5'd0, 32'h0);
        repeat (200) tick();
        chk(fs_n == 0 && oe_n == 0 && rx_n == 0, "R6 idle without data",
            fs_n + oe_n + rx_n, 0);

        // R5 R8: periodic mode repeats the last word on underrun
        do_reset(2'd0, 2'd0, 8'd1, 1'b0, 1'b0, 5'd0, 32'h0);
        push(24'h5A);
        wait_rx(1);
        chk(und_n == 0, "R8 no underrun while full", und_n, 0);
        chk(rx_log[0] == 24'h5A, "R5 first periodic word", {8'd0, rx_log[0]}, 32'h5A);
        wait_rx(2);
        chk(rx_log[1] == 24'h5A, "R8 repeated word", {8'd0, rx_log[1]}, 32'h5A);
        chk(und_n == 1, "R8 underrun pulse", und_n, 1);
        chk(fs_n == 2, "R5 sync per frame", fs_n, 2);

        // R7: network frame with slots 0 and 2 enabled out of 4
        do_reset(2'd2, 2'd0, 8'd1, 1'b0, 1'b0, 5'd3, 32'h5);
        push(24'h81);
        push(24'h7E);
        wait_rx(4);
        chk(rx_log[0] == 24'h81, "R7 slot0 data", {8'd0, rx_log[0]}, 32'h81);
        chk(rx_log[1] == 24'hFF, "R7 slot1 released", {8'd0, rx_log[1]}, 32'hFF);
        chk(rx_log[2] == 24'h7E, "R7 slot2 data", {8'd0, rx_log[2]}, 32'h7E);
        chk(rx_log[3] == 24'hFF, "R7 slot3 released", {8'd0, rx_log[3]}, 32'hFF);
        chk(slot_log[2] == 5'd2 && slot_log[3] == 5'd3, "R11 slot numbers",
            {22'd0, slot_log[2], slot_log[3]}, {22'd0, 5'd2, 5'd3});
        chk(fs_n == 1, "R4 one sync per network frame", fs_n, 1);
        chk(und_n == 0, "R7 masked slots do not consume", und_n, 0);

        // R9: a write while full is ignored
        do_reset(2'd2, 2'd0, 8'd1, 1'b0, 1'b0, 5'd3, 32'h1);
        push(24'h11);
        push(24'h22);
        wr_raw(24'h33);
        wait_rx(5);
        chk(rx_log[0] == 24'h11, "R9 first word", {8'd0, rx_log[0]}, 32'h11);
        chk(rx_log[4] == 24'h22, "R9 write while full ignored", {8'd0, rx_log[4]}, 32'h22);
        chk(und_n == 0, "R9 held word sent next frame", und_n, 0);

        // R10: gated clock bursts
        do_reset(2'd1, 2'd0, 8'd1, 1'b1, 1'b0, 5'd0, 32'h0);
        push(24'h3C);
        push(24'hC3);
        wait_rx(2);
        repeat (100) tick();
        chk(rises == 16, "R10 clock edges only in words", rises, 16);
        chk(fs_n == 0, "R10 no frame sync", fs_n, 0);
        chk(maxp >= 8, "R10 idle bit between words", maxp, 8);
        chk(rx_log[0] == 24'h3C && rx_log[1] == 24'hC3, "R10 R11 gated words",
            {8'd0, rx_log[1]}, 32'hC3);

        // R12: external clock and sync
        do_reset(2'd2, 2'd1, 8'd1, 1'b0, 1'b1, 5'd3, 32'h0);
        for (int i = 0; i < 5; i++) ext_bit(1'b0, 1'b1);
        repeat (6) tick();
        chk(rx_n == 0, "R12 bits before sync ignored", rx_n, 0);
        ext_word(1'b1, 12'hB4C);
        ext_word(1'b0, 12'h3F1);
        repeat (6) tick();
        chk(rx_n == 2, "R12 word count", rx_n, 2);
        chk(rx_log[0] == 24'hB4C && slot_log[0] == 5'd0, "R12 synced word",
            {8'd0, rx_log[0]}, 32'hB4C);
        chk(rx_log[1] == 24'h3F1 && slot_log[1] == 5'd1, "R12 next slot word",
            {3'd0, slot_log[1], rx_log[1]}, {3'd0, 5'd1, 24'h3F1});

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule